// File: doc/BRIEF.md
# Shift and Rotate Unit with Flag Outputs

This block carries out one of seven single-operand shift or rotate operations on a 32-bit word. A caller pulses `start_i` for one cycle with the operand, an operation code, a count-source select, the two candidate count values and the incoming carry flag. On the next clock edge the block presents the result with a write enable. It also presents five flag values (sign, zero, parity, carry, overflow), each with its own update enable, so that a surrounding execution stage can merge them into its flag register.

The count is either a constant one or the low five bits of one of two 8-bit count inputs. Plain rotates update only carry and overflow. The rotates through carry treat the operand and the incoming carry as one 33-bit ring. The three shifts also update sign, zero and parity. A zero count or the unused operation code leaves every enable low, so nothing is written.

Top module: `shift_rot_unit`

## Requirements
- R1: Outputs are registered. The result, the flags and all enables reflect the inputs sampled at the rising edge where `start_i` is high. They are valid after that edge until the next one. After reset, and after any edge where `start_i` is low, every enable is 0, and `result_o` and every flag value are 0.
- R2: The count-source select works as follows. 2'b00 gives a count of 1. 2'b01 gives bits [4:0] of `imm_i`. 2'b10 and 2'b11 give bits [4:0] of `cnt_reg_i`. The upper count bits are ignored.
- R3: A count of 0, or operation code 7, deasserts `wr_en_o` and all five flag enables.
- R4: Code 0 rotates left and code 1 rotates right. Carry is result bit 0 for code 0 and result bit 31 for code 1. Sign, zero and parity enables stay 0.
- R5: Code 2 (left) and code 3 (right) rotate the 33-bit ring {carry_i, operand} by the count. The result is the low 32 ring bits and the new carry is the ring's top bit. Sign, zero and parity enables stay 0.
- R6: The overflow enable is 1 only for a nonzero operation with count 1. For codes 0 to 3, overflow is then operand bit 31 XOR result bit 31.
- R7: Code 4 shifts left with zero fill. Carry is the last bit shifted out, which is operand bit (32 - count). Overflow at count 1 is result bit 31 XOR the new carry.
- R8: Code 5 shifts right with zero fill. Carry is operand bit (count - 1). Overflow at count 1 is operand bit 31.
- R9: Code 6 shifts right and fills with copies of operand bit 31. Carry is operand bit (count - 1). Overflow at count 1 is 0.
- R10: Codes 4 to 6 set the sign, zero and parity enables. Sign is result bit 31. Zero is 1 when the result is all zeros. Parity is 1 when result bits [7:0] hold an even number of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation request strobe |
| op_i | input | 3 | Operation code 0..7 |
| cnt_sel_i | input | 2 | Count source select |
| imm_i | input | 8 | Immediate count byte |
| cnt_reg_i | input | 8 | Count register byte |
| carry_i | input | 1 | Incoming carry flag |
| operand_i | input | 32 | Operand word |
| result_o | output | 32 | Result word |
| wr_en_o | output | 1 | Result write enable |
| sf_o | output | 1 | Sign value |
| sf_we_o | output | 1 | Sign update enable |
| zf_o | output | 1 | Zero value |
| zf_we_o | output | 1 | Zero update enable |
| pf_o | output | 1 | Parity value |
| pf_we_o | output | 1 | Parity update enable |
| cf_o | output | 1 | Carry value |
| cf_we_o | output | 1 | Carry update enable |
| of_o | output | 1 | Overflow value |
| of_we_o | output | 1 | Overflow update enable |

## Verification
Every output of this block is due exactly one rising edge after the edge that samples `start_i`. When `start_i` is low, all outputs return to zero one edge later. The bench changes inputs on the falling edge, and it reads the result, the flag values and all six enables together on the next falling edge. In that window exactly one sampling edge has passed. A back-to-back sequence checks that the second request is read one falling edge after the first, and an idle edge is checked for cleared enables.

// File: rtl/srt_pkg.sv
package srt_pkg;

   typedef enum logic [2:0] {
      OP_ROL  = 3'd0,
      OP_ROR  = 3'd1,
      OP_RCL  = 3'd2,
      OP_RCR  = 3'd3,
      OP_SHL  = 3'd4,
      OP_SHR  = 3'd5,
      OP_SAR  = 3'd6,
      OP_NONE = 3'd7
   } srt_op_e;

   localparam logic [1:0] CSEL_ONE = 2'b00;
   localparam logic [1:0] CSEL_IMM = 2'b01;

   typedef struct packed {
      logic sf;
      logic zf;
      logic pf;
      logic cf;
      logic of;
   } srt_flags_t;

endpackage

// File: rtl/srt_count_sel.sv
module srt_count_sel
   import srt_pkg::*;
#(
   parameter int SRC_W = 8,
   parameter int CNT_W = 5
) (
   input  logic [1:0]       sel_i,
   input  logic [SRC_W-1:0] imm_i,
   input  logic [SRC_W-1:0] reg_i,
   output logic [CNT_W-1:0] cnt_o
);

   logic [SRC_W-1:0] raw;

   always_comb begin
      if (sel_i == CSEL_ONE)      raw = SRC_W'(1);
      else if (sel_i == CSEL_IMM) raw = imm_i;
      else                        raw = reg_i;
      cnt_o = CNT_W'(raw);
   end

endmodule

// File: rtl/srt_parity.sv
module srt_parity #(
   parameter int PAR_W = 8
) (
   input  logic [PAR_W-1:0] data_i,
   output logic             even_o
);

   logic [PAR_W:0] chain;

   assign chain[0] = 1'b1;
   for (genvar k = 0; k < PAR_W; k++) begin : g_xor
      assign chain[k+1] = chain[k] ^ data_i[k];
   end
   assign even_o = chain[PAR_W];

endmodule

// File: rtl/srt_datapath.sv
module srt_datapath
   import srt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 5
) (
   input  srt_op_e           op_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cf_o,
   output logic              of_o,
   output logic              szp_o
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0]   ring;
   logic [DATA_W:0]   ring_l;
   logic [DATA_W:0]   ring_r;
   logic [DATA_W:0]   shl_w;
   logic [DATA_W:0]   shr_w;
   logic [DATA_W:0]   sar_w;
   logic [DATA_W-1:0] rol_w;
   logic [DATA_W-1:0] ror_w;
   int                cn;

   always_comb begin
      cn     = int'(cnt_i);
      ring   = {cin_i, a_i};
      ring_l = (ring << cnt_i) | (ring >> (DATA_W + 1 - cn));
      ring_r = (ring >> cnt_i) | (ring << (DATA_W + 1 - cn));
      rol_w  = (a_i << cnt_i) | (a_i >> (DATA_W - cn));
      ror_w  = (a_i >> cnt_i) | (a_i << (DATA_W - cn));
      shl_w  = {1'b0, a_i} << cnt_i;
      shr_w  = {a_i, 1'b0} >> cnt_i;
      sar_w  = $signed({a_i, 1'b0}) >>> cnt_i;

      res_o = '0;
      cf_o  = 1'b0;
      of_o  = 1'b0;
      szp_o = 1'b0;
      unique case (op_i)
         OP_ROL: begin
            res_o = rol_w;
            cf_o  = rol_w[0];
            of_o  = a_i[MSB] ^ rol_w[MSB];
         end
         OP_ROR: begin
            res_o = ror_w;
            cf_o  = ror_w[MSB];
            of_o  = a_i[MSB] ^ ror_w[MSB];
         end
         OP_RCL: begin
            res_o = ring_l[MSB:0];
            cf_o  = ring_l[DATA_W];
            of_o  = a_i[MSB] ^ ring_l[MSB];
         end
         OP_RCR: begin
            res_o = ring_r[MSB:0];
            cf_o  = ring_r[DATA_W];
            of_o  = a_i[MSB] ^ ring_r[MSB];
         end
         OP_SHL: begin
            res_o = shl_w[MSB:0];
            cf_o  = shl_w[DATA_W];
            of_o  = shl_w[MSB] ^ shl_w[DATA_W];
            szp_o = 1'b1;
         end
         OP_SHR: begin
            res_o = shr_w[DATA_W:1];
            cf_o  = shr_w[0];
            of_o  = a_i[MSB];
            szp_o = 1'b1;
         end
         OP_SAR: begin
            res_o = sar_w[DATA_W:1];
            cf_o  = sar_w[0];
            of_o  = 1'b0;
            szp_o = 1'b1;
         end
         default: begin
            res_o = '0;
         end
      endcase
   end

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
   import srt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SRC_W  = 8,
   parameter int PAR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        op_i,
   input  logic [1:0]        cnt_sel_i,
   input  logic [SRC_W-1:0]  imm_i,
   input  logic [SRC_W-1:0]  cnt_reg_i,
   input  logic              carry_i,
   input  logic [DATA_W-1:0] operand_i,
   output logic [DATA_W-1:0] result_o,
   output logic              wr_en_o,
   output logic              sf_o,
   output logic              sf_we_o,
   output logic              zf_o,
   output logic              zf_we_o,
   output logic              pf_o,
   output logic              pf_we_o,
   output logic              cf_o,
   output logic              cf_we_o,
   output logic              of_o,
   output logic              of_we_o
);

   localparam int CNT_W = $clog2(DATA_W);

   if (DATA_W < PAR_W || (1 << CNT_W) != DATA_W) begin : g_bad_width
      $error("shift_rot_unit: DATA_W must be a power of two and at least PAR_W");
   end
   if (SRC_W < CNT_W) begin : g_bad_src
      $error("shift_rot_unit: SRC_W too narrow for the count");
   end

   logic [CNT_W-1:0]  cnt_w;
   logic [DATA_W-1:0] res_c;
   logic              cf_c, of_c, szp_c, pf_c, act_c, one_c;
   srt_op_e           op_e;
   srt_flags_t        val_d, val_q, we_d, we_q;
   logic [DATA_W-1:0] res_d, res_q;
   logic              wr_q;

   assign op_e = srt_op_e'(op_i);

   srt_count_sel #(.SRC_W(SRC_W), .CNT_W(CNT_W)) cnt_sel_i_u (
      .sel_i (cnt_sel_i),
      .imm_i (imm_i),
      .reg_i (cnt_reg_i),
      .cnt_o (cnt_w)
   );

   srt_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dp_u (
      .op_i  (op_e),
      .cnt_i (cnt_w),
      .a_i   (operand_i),
      .cin_i (carry_i),
      .res_o (res_c),
      .cf_o  (cf_c),
      .of_o  (of_c),
      .szp_o (szp_c)
   );

   srt_parity #(.PAR_W(PAR_W)) par_u (
      .data_i (res_c[PAR_W-1:0]),
      .even_o (pf_c)
   );

   always_comb begin
      act_c = start_i && (cnt_w != '0) && (op_e != OP_NONE);
      one_c = (cnt_w == CNT_W'(1));
      we_d.cf = act_c;
      we_d.of = act_c && one_c;
      we_d.sf = act_c && szp_c;
      we_d.zf = act_c && szp_c;
      we_d.pf = act_c && szp_c;
      val_d.cf = we_d.cf && cf_c;
      val_d.of = we_d.of && of_c;
      val_d.sf = we_d.sf && res_c[DATA_W-1];
      val_d.zf = we_d.zf && (res_c == '0);
      val_d.pf = we_d.pf && pf_c;
      res_d    = act_c ? res_c : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         wr_q  <= 1'b0;
         val_q <= '0;
         we_q  <= '0;
      end else begin
         res_q <= res_d;
         wr_q  <= act_c;
         val_q <= val_d;
         we_q  <= we_d;
      end
   end

   assign result_o = res_q;
   assign wr_en_o  = wr_q;
   assign sf_o     = val_q.sf;
   assign sf_we_o  = we_q.sf;
   assign zf_o     = val_q.zf;
   assign zf_we_o  = we_q.zf;
   assign pf_o     = val_q.pf;
   assign pf_we_o  = we_q.pf;
   assign cf_o     = val_q.cf;
   assign cf_we_o  = we_q.cf;
   assign of_o     = val_q.of;
   assign of_we_o  = we_q.of;

   a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (!wr_en_o && !cf_we_o && !of_we_o && result_o == '0));

   a_r3_zero_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && cnt_w == '0) |=> (!wr_en_o && !sf_we_o && !zf_we_o && !pf_we_o && !cf_we_o && !of_we_o));

   a_r4_rotate_keeps_szp: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i < 3'd4) |=> (!sf_we_o && !zf_we_o && !pf_we_o));

   a_r6_overflow_count_one: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && cnt_w != CNT_W'(1)) |=> !of_we_o);

   a_r9_sar_overflow_low: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i == 3'd6 && cnt_w == CNT_W'(1)) |=> (of_we_o && !of_o));

   a_r10_zero_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
      zf_we_o |-> (zf_o == (result_o == '0)));

   a_r3_flags_need_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cf_we_o || of_we_o || sf_we_o) |-> wr_en_o);

endmodule

// File: tb/shift_rot_unit_tb_top.sv
`timescale 1ns/1ps
module shift_rot_unit_tb_top;

   typedef struct packed {
      logic [2:0]  op;
      logic [1:0]  sel;
      logic [7:0]  imm;
      logic [7:0]  creg;
      logic        cin;
      logic [31:0] a;
   } vec_t;

   localparam int NVEC = 17;
   localparam vec_t VECS [NVEC] = '{
      '{3'd0, 2'b01, 8'h04, 8'h00, 1'b0, 32'h8000_0001},
      '{3'd0, 2'b00, 8'h00, 8'h00, 1'b1, 32'h4000_0000},
      '{3'd1, 2'b10, 8'h00, 8'h08, 1'b0, 32'h1234_5678},
      '{3'd1, 2'b00, 8'h00, 8'h00, 1'b0, 32'h0000_0001},
      '{3'd2, 2'b01, 8'h01, 8'h00, 1'b1, 32'h8000_0000},
      '{3'd2, 2'b11, 8'h00, 8'h1F, 1'b0, 32'hF000_000F},
      '{3'd3, 2'b00, 8'h00, 8'h00, 1'b1, 32'h0000_0002},
      '{3'd3, 2'b01, 8'h10, 8'h00, 1'b1, 32'hABCD_1234},
      '{3'd4, 2'b00, 8'h00, 8'h00, 1'b0, 32'hC000_0000},
      '{3'd4, 2'b01, 8'h1F, 8'h00, 1'b0, 32'h0000_0003},
      '{3'd5, 2'b00, 8'h00, 8'h00, 1'b0, 32'h8000_0001},
      '{3'd5, 2'b10, 8'h00, 8'h3F, 1'b0, 32'h8000_0000},
      '{3'd6, 2'b00, 8'h00, 8'h00, 1'b1, 32'h8000_0003},
      '{3'd6, 2'b01, 8'h1F, 8'h00, 1'b0, 32'h7FFF_FFFF},
      '{3'd4, 2'b01, 8'h20, 8'h00, 1'b1, 32'hFFFF_FFFF},
      '{3'd7, 2'b00, 8'h00, 8'h00, 1'b1, 32'h1357_9BDF},
      '{3'd0, 2'b01, 8'h21, 8'h05, 1'b0, 32'hC000_0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = '0;
   logic [1:0]  sel = '0;
   logic [7:0]  imm = '0;
   logic [7:0]  creg = '0;
   logic        cin = 1'b0;
   logic [31:0] a = '0;
   logic [31:0] result;
   logic        wr_en, sf, sf_we, zf, zf_we, pf, pf_we, cf, cf_we, of, of_we;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   shift_rot_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .cnt_sel_i(sel),
      .imm_i(imm), .cnt_reg_i(creg), .carry_i(cin), .operand_i(a),
      .result_o(result), .wr_en_o(wr_en),
      .sf_o(sf), .sf_we_o(sf_we), .zf_o(zf), .zf_we_o(zf_we),
      .pf_o(pf), .pf_we_o(pf_we), .cf_o(cf), .cf_we_o(cf_we),
      .of_o(of), .of_we_o(of_we)
   );

   // observation: {wr, result, sf_we, sf, zf_we, zf, pf_we, pf, cf_we, cf, of_we, of}
   function automatic logic [42:0] observe();
      return {wr_en, result, sf_we, sf, zf_we, zf, pf_we, pf, cf_we, cf, of_we, of};
   endfunction

   function automatic int count_of(vec_t v);
      if (v.sel == 2'b00) return 1;
      if (v.sel == 2'b01) return int'(v.imm & 8'h1F);
      return int'(v.creg & 8'h1F);
   endfunction

   // bit-serial reference built from the requirements
   function automatic logic [42:0] model(vec_t v);
      int          c = count_of(v);
      logic [31:0] r = v.a;
      logic        cy = v.cin;
      logic        ov = 1'b0;
      logic        szp = 1'b0;
      int          ones = 0;
      if (c == 0 || v.op == 3'd7) return '0;
      for (int k = 0; k < c; k++) begin
         case (v.op)
            3'd0: r = {r[30:0], r[31]};
            3'd1: r = {r[0], r[31:1]};
            3'd2: {cy, r} = {r, cy};
            3'd3: {r, cy} = {cy, r};
            3'd4: begin cy = r[31]; r = {r[30:0], 1'b0}; end
            3'd5: begin cy = r[0];  r = {1'b0, r[31:1]}; end
            default: begin cy = r[0]; r = {r[31], r[31:1]}; end
         endcase
      end
      case (v.op)
         3'd0: cy = r[0];
         3'd1: cy = r[31];
         default: ;
      endcase
      if (v.op < 3'd4) ov = v.a[31] ^ r[31];
      else if (v.op == 3'd4) ov = r[31] ^ cy;
      else if (v.op == 3'd5) ov = v.a[31];
      else ov = 1'b0;
      szp = (v.op >= 3'd4);
      for (int k = 0; k < 8; k++) ones += int'(r[k]);
      return {1'b1, r,
              szp, szp & r[31],
              szp, szp & (r == 32'd0),
              szp, szp & (ones % 2 == 0),
              1'b1, cy,
              (c == 1), (c == 1) & ov};
   endfunction

   function automatic string tag_of(vec_t v);
      int    c = count_of(v);
      string t;
      if (c == 0 || v.op == 3'd7) t = "R3";
      else case (v.op)
         3'd0, 3'd1: t = "R4";
         3'd2, 3'd3: t = "R5";
         3'd4: t = "R7 R10";
         3'd5: t = "R8 R10";
         default: t = "R9 R10";
      endcase
      if (c == 1) t = {t, " R6"};
      return {"R2 ", t};
   endfunction

   task automatic check(string tag, logic [42:0] got, logic [42:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic drive(vec_t v);
      start = 1'b1; op = v.op; sel = v.sel; imm = v.imm;
      creg = v.creg; cin = v.cin; a = v.a;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset", observe(), '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset idle", observe(), '0);

      // table walk: drive on one falling edge, read on the next
      for (int i = 0; i < NVEC; i++) begin
         drive(VECS[i]);
         @(negedge clk);
         start = 1'b0;
         check($sformatf("%s vec%0d", tag_of(VECS[i]), i), observe(), model(VECS[i]));
      end

      // R1: an idle edge clears everything
      @(negedge clk);
      check("R1 idle edge", observe(), '0);

      // R1: back-to-back requests, each due one edge later
      drive(VECS[5]);
      @(negedge clk);
      drive(VECS[12]);
      check("R1 R5 back-to-back first", observe(), model(VECS[5]));
      @(negedge clk);
      start = 1'b0;
      check("R1 R9 back-to-back second", observe(), model(VECS[12]));

      // R3: code 7 with a nonzero count register still writes nothing
      drive('{3'd7, 2'b10, 8'h00, 8'h03, 1'b1, 32'hFFFF_0000});
      @(negedge clk);
      start = 1'b0;
      check("R3 code7 quiet", observe(), '0);

      // R2: count register upper bits ignored (0xE1 -> count 1) on a right shift
      drive('{3'd5, 2'b11, 8'h07, 8'hE1, 1'b0, 32'h0000_00FF});
      @(negedge clk);
      start = 1'b0;
      check("R2 R8 masked count", observe(),
            model('{3'd5, 2'b00, 8'h00, 8'h00, 1'b0, 32'h0000_00FF}));

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule